// File: doc/BRIEF.md
# UART Interrupt Priority Identification

This block gathers the interrupt sources of a UART receiver/transmitter pair and reports the most urgent pending one as an 8-bit identification byte. It also drives an active-high interrupt line. The sources are receive line errors, received data at or above the FIFO trigger depth, a receive character timeout, an empty transmit holding register and a modem status change. The block latches the event-style sources and clears them on the bus accesses that service them. Level-style sources follow the receive FIFO occupancy.

The surrounding UART supplies the interrupt-enable nibble, the FIFO mode and trigger select, the receive FIFO level and one-cycle event pulses. Those pulses are: a line error was captured, a character arrived, a character time elapsed, and the holding register emptied. It also supplies one-cycle strobes for reads of the receive buffer, line status, modem status and identification registers, and for writes of the holding register. The identification byte is a combinational view of the latched state, so it is valid in the same cycle that the bus reads it.

Top module: `uart_irq_ident`

## Requirements
- R1: With nothing pending, identification bit 0 reads 1 and `irq` is low. Whenever an enabled source is pending, bit 0 reads 0.
- R2: A line error pulse latches a line-status source with code 011 in bits [3:1]. The source clears only on a line-status read strobe. If a set and a clear arrive in the same cycle, the set wins.
- R3: Received-data-available (code 010) is pending while the receive level is at or above the trigger depth. In FIFO mode, trigger select 00, 01, 10 and 11 gives 1, 4, 8 and 14 bytes. In non-FIFO mode the depth is 1. The source clears as soon as the level drops below the depth.
- R4: In FIFO mode, character timeout (code 110) is raised once `TO_CHARS` (default 4) character-time ticks have passed with a nonzero receive level, no character arriving and no receive read. A receive read or an arrival restarts the count and removes the timeout. The timeout is never reported in non-FIFO mode.
- R5: A holding-empty pulse latches a source with code 001. It clears on a holding-register write, or on an identification read made while 001 is the reported code.
- R6: An identification read made while a higher-priority source is reported leaves the holding-empty source pending.
- R7: A modem-change pulse latches a source with code 000 and bit 0 = 0. It clears on a modem-status read strobe.
- R8: Enable bit 0 gates both received-data and timeout, bit 1 gates holding-empty, bit 2 gates line status and bit 3 gates modem status. A disabled source is not reported, but stays latched, and it is reported as soon as it is enabled.
- R9: Priority from highest to lowest is line status, received data, timeout, holding empty, modem status.
- R10: Bits [7:6] read 11 in FIFO mode and 00 otherwise. Bits [5:4] always read 00.
- R11: `irq` is high exactly when a source is reported and `out2` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier | input | 4 | Interrupt enables: 0 rx data/timeout, 1 holding empty, 2 line status, 3 modem |
| fifo_en | input | 1 | FIFO mode active |
| trig_sel | input | 2 | Receive trigger depth select |
| rx_level | input | LVL_W | Receive FIFO occupancy |
| line_err | input | 1 | Pulse: line error captured |
| rx_arrive | input | 1 | Pulse: character written into receive FIFO |
| char_tick | input | 1 | Pulse: one character time elapsed |
| tx_empty_evt | input | 1 | Pulse: holding register became empty |
| modem_chg | input | 1 | Pulse: modem input changed |
| rd_rbr | input | 1 | Strobe: receive buffer read |
| rd_lsr | input | 1 | Strobe: line status read |
| rd_msr | input | 1 | Strobe: modem status read |
| rd_iir | input | 1 | Strobe: identification read |
| wr_thr | input | 1 | Strobe: holding register write |
| out2 | input | 1 | Interrupt output gate |
| iir | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
A stuck or lost latched flag shows at the ports in the first clock after the pulse or strobe that should change it. The code field holds the wrong value, or bit 0 stays at 1, so every set and clear is checked at the next falling edge. A timeout counter that runs too fast or too slow shows one tick early or one tick late, so the bench checks just before and just at the limit. A priority or enable fault shows as a wrong code while several sources are pending. The bench peels the sources off one at a time, and each step exposes the next code in the order.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    typedef enum logic [2:0] {
        SRC_LINE    = 3'b011,
        SRC_RXDATA  = 3'b010,
        SRC_TIMEOUT = 3'b110,
        SRC_TXEMPTY = 3'b001,
        SRC_MODEM   = 3'b000
    } src_code_e;

    typedef struct packed {
        logic line;
        logic rxdata;
        logic timeout;
        logic txempty;
        logic modem;
    } src_vec_t;

    // Indices of the latched (event-driven) sources
    localparam int STK_LINE  = 0;
    localparam int STK_TX    = 1;
    localparam int STK_MODEM = 2;
    localparam int NUM_STK   = 3;

    function automatic logic [4:0] trig_depth(input logic fifo, input logic [1:0] sel);
        if (!fifo) return 5'd1;
        case (sel)
            2'b00:   return 5'd1;
            2'b01:   return 5'd4;
            2'b10:   return 5'd8;
            default: return 5'd14;
        endcase
    endfunction

    function automatic logic [7:0] make_iir(input logic fifo, input logic pend,
                                            input src_code_e code);
        return {{2{fifo}}, 2'b00, (pend ? code : 3'b000), ~pend};
    endfunction

endpackage

// File: rtl/uirq_sticky.sv
module uirq_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/uirq_rx_timer.sv
module uirq_rx_timer #(
    parameter int LVL_W    = 5,
    parameter int TO_CHARS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_en,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             char_tick,
    input  logic             rx_arrive,
    input  logic             rd_rbr,
    output logic             timeout
);
    localparam int CW = $clog2(TO_CHARS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TO_CHARS);

    logic [CW-1:0] cnt;
    logic          has_data;

    assign has_data = (rx_level != '0);

    always_ff @(posedge clk) begin
        if (rst || !fifo_en || !has_data || rx_arrive || rd_rbr)
            cnt <= '0;
        else if (char_tick && cnt != LIMIT)
            cnt <= cnt + 1'b1;
    end

    assign timeout = (cnt == LIMIT) && fifo_en && has_data && !rd_rbr;
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
    import uirq_pkg::*;
(
    input  src_vec_t  pend,
    output logic      any,
    output src_code_e code
);
    always_comb begin
        any  = 1'b1;
        code = SRC_MODEM;
        if (pend.line)         code = SRC_LINE;
        else if (pend.rxdata)  code = SRC_RXDATA;
        else if (pend.timeout) code = SRC_TIMEOUT;
        else if (pend.txempty) code = SRC_TXEMPTY;
        else if (pend.modem)   code = SRC_MODEM;
        else                   any  = 1'b0;
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uirq_pkg::*;
#(
    parameter int LVL_W    = 5,
    parameter int TO_CHARS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       ier,
    input  logic             fifo_en,
    input  logic [1:0]       trig_sel,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             line_err,
    input  logic             rx_arrive,
    input  logic             char_tick,
    input  logic             tx_empty_evt,
    input  logic             modem_chg,
    input  logic             rd_rbr,
    input  logic             rd_lsr,
    input  logic             rd_msr,
    input  logic             rd_iir,
    input  logic             wr_thr,
    input  logic             out2,
    output logic [7:0]       iir,
    output logic             irq
);
    logic [NUM_STK-1:0] stk_set, stk_clr, stk_q;
    logic               timeout, rx_hit, any;
    src_vec_t           pend;
    src_code_e          code;

    // Clear of holding-empty depends on what is being reported
    assign stk_set[STK_LINE]  = line_err;
    assign stk_clr[STK_LINE]  = rd_lsr;
    assign stk_set[STK_TX]    = tx_empty_evt;
    assign stk_clr[STK_TX]    = wr_thr || (rd_iir && any && code == SRC_TXEMPTY);
    assign stk_set[STK_MODEM] = modem_chg;
    assign stk_clr[STK_MODEM] = rd_msr;

    for (genvar i = 0; i < NUM_STK; i++) begin : g_stk
        uirq_sticky u_flag (
            .clk (clk),
            .rst (rst),
            .set (stk_set[i]),
            .clr (stk_clr[i]),
            .q   (stk_q[i])
        );
    end

    uirq_rx_timer #(.LVL_W(LVL_W), .TO_CHARS(TO_CHARS)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .fifo_en   (fifo_en),
        .rx_level  (rx_level),
        .char_tick (char_tick),
        .rx_arrive (rx_arrive),
        .rd_rbr    (rd_rbr),
        .timeout   (timeout)
    );

    assign rx_hit = (32'(rx_level) >= 32'(trig_depth(fifo_en, trig_sel)));

    always_comb begin
        pend.line    = stk_q[STK_LINE]  && ier[2];
        pend.rxdata  = rx_hit           && ier[0];
        pend.timeout = timeout          && ier[0];
        pend.txempty = stk_q[STK_TX]    && ier[1];
        pend.modem   = stk_q[STK_MODEM] && ier[3];
    end

    uirq_prio u_prio (
        .pend (pend),
        .any  (any),
        .code (code)
    );

    assign iir = make_iir(fifo_en, any, code);
    assign irq = any && out2;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] ier,
    input logic       fifo_en,
    input logic       line_err,
    input logic       tx_empty_evt,
    input logic       modem_chg,
    input logic       rd_msr,
    input logic       wr_thr,
    input logic       out2,
    input logic [7:0] iir,
    input logic       irq
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        iir[0] |-> !irq);

    assert_line_top_R2: assert property (@(posedge clk) disable iff (rst)
        (line_err && ier[2]) |=> (!ier[2] || iir[3:0] == 4'b0110));

    assert_no_timeout_nofifo_R4: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |-> iir[3:1] != 3'b110);

    assert_thr_write_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_thr && !tx_empty_evt) |=> iir[3:1] != 3'b001);

    assert_msr_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_msr && !modem_chg) |=> iir[3:0] != 4'b0000);

    assert_mode_bits_R10: assert property (@(posedge clk) disable iff (rst)
        iir[7:4] == {{2{fifo_en}}, 2'b00});

    assert_irq_gate_R11: assert property (@(posedge clk) disable iff (rst)
        irq |-> (out2 && !iir[0]));
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ier          (ier),
    .fifo_en      (fifo_en),
    .line_err     (line_err),
    .tx_empty_evt (tx_empty_evt),
    .modem_chg    (modem_chg),
    .rd_msr       (rd_msr),
    .wr_thr       (wr_thr),
    .out2         (out2),
    .iir          (iir),
    .irq          (irq)
);

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] ier = 4'h0;
    logic       fifo_en = 1'b0;
    logic [1:0] trig_sel = 2'b00;
    logic [4:0] rx_level = 5'd0;
    logic line_err = 0, rx_arrive = 0, char_tick = 0, tx_empty_evt = 0, modem_chg = 0;
    logic rd_rbr = 0, rd_lsr = 0, rd_msr = 0, rd_iir = 0, wr_thr = 0, out2 = 1'b1;
    logic [7:0] iir;
    logic       irq;

    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    uart_irq_ident uut (
        .clk(clk), .rst(rst), .ier(ier), .fifo_en(fifo_en), .trig_sel(trig_sel),
        .rx_level(rx_level), .line_err(line_err), .rx_arrive(rx_arrive),
        .char_tick(char_tick), .tx_empty_evt(tx_empty_evt), .modem_chg(modem_chg),
        .rd_rbr(rd_rbr), .rd_lsr(rd_lsr), .rd_msr(rd_msr), .rd_iir(rd_iir),
        .wr_thr(wr_thr), .out2(out2), .iir(iir), .irq(irq)
    );

    function automatic logic [7:0] exp_iir(input bit fifo, input bit pend, input logic [2:0] code);
        return {fifo, fifo, 2'b00, pend ? code : 3'b000, ~pend};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    // Pulse helpers: high for exactly one rising edge, then sampled at the next falling edge
    task automatic p_line();  line_err = 1;     settle(); line_err = 0;     endtask
    task automatic p_tx();    tx_empty_evt = 1; settle(); tx_empty_evt = 0; endtask
    task automatic p_modem(); modem_chg = 1;    settle(); modem_chg = 0;    endtask
    task automatic p_tick();  char_tick = 1;    settle(); char_tick = 0;    endtask
    task automatic p_rbr();   rd_rbr = 1;       settle(); rd_rbr = 0;       endtask
    task automatic p_lsr();   rd_lsr = 1;       settle(); rd_lsr = 0;       endtask
    task automatic p_msr();   rd_msr = 1;       settle(); rd_msr = 0;       endtask
    task automatic p_iir();   rd_iir = 1;       settle(); rd_iir = 0;       endtask
    task automatic p_thr();   wr_thr = 1;       settle(); wr_thr = 0;       endtask

    task automatic t_reset();
        settle(); rst = 1; settle(); settle(); rst = 0; settle();
        chk("R1 idle after reset", iir, exp_iir(0, 0, 3'b000));
        chk("R1 irq low after reset", {7'd0, irq}, 8'd0);
    endtask

    task automatic t_line();
        fifo_en = 0; ier = 4'b0100; settle();
        p_line();
        chk("R2 line status set", iir, exp_iir(0, 1, 3'b011));
        p_rbr();
        chk("R2 line survives rbr read", iir, exp_iir(0, 1, 3'b011));
        line_err = 1; rd_lsr = 1; settle(); line_err = 0; rd_lsr = 0;
        chk("R2 set beats clear", iir, exp_iir(0, 1, 3'b011));
        p_lsr();
        chk("R2 lsr read clears", iir, exp_iir(0, 0, 3'b000));
    endtask

    task automatic t_rxdata();
        logic [4:0] depth [4] = '{5'd1, 5'd4, 5'd8, 5'd14};
        fifo_en = 1; ier = 4'b0001;
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            rx_level = depth[s] - 5'd1; settle();
            chk($sformatf("R3 below depth sel %0d", s), iir, exp_iir(1, 0, 3'b000));
            rx_level = depth[s]; settle();
            chk($sformatf("R3 at depth sel %0d", s), iir, exp_iir(1, 1, 3'b010));
        end
        rx_level = 5'd13; settle();
        chk("R3 clears below depth", iir, exp_iir(1, 0, 3'b000));
        fifo_en = 0; trig_sel = 2'b11; rx_level = 5'd1; settle();
        chk("R3 non-FIFO depth one", iir, exp_iir(0, 1, 3'b010));
        rx_level = 5'd0; settle();
        chk("R10 non-FIFO idle", iir, 8'h01);
    endtask

    task automatic t_timeout();
        fifo_en = 1; trig_sel = 2'b11; ier = 4'b0001; rx_level = 5'd2; settle();
        for (int k = 0; k < 3; k++) p_tick();
        chk("R4 no timeout after 3 ticks", iir, exp_iir(1, 0, 3'b000));
        p_tick();
        chk("R4 timeout after 4 ticks", iir, exp_iir(1, 1, 3'b110));
        p_rbr();
        chk("R4 rbr read clears timeout", iir, exp_iir(1, 0, 3'b000));
        for (int k = 0; k < 3; k++) p_tick();
        rx_arrive = 1; settle(); rx_arrive = 0;
        p_tick();
        chk("R4 arrival restarts count", iir, exp_iir(1, 0, 3'b000));
        fifo_en = 0; settle();
        for (int k = 0; k < 5; k++) p_tick();
        chk("R4 no timeout without FIFO", iir, exp_iir(0, 1, 3'b010));
        rx_level = 5'd0; settle();
    endtask

    task automatic t_txempty();
        fifo_en = 1; ier = 4'b0010; settle();
        p_tx();
        chk("R5 holding empty set", iir, exp_iir(1, 1, 3'b001));
        p_thr();
        chk("R5 thr write clears", iir, exp_iir(1, 0, 3'b000));
        p_tx();
        p_iir();
        chk("R5 iir read clears reported", iir, exp_iir(1, 0, 3'b000));
        ier = 4'b0110; p_tx(); p_line();
        p_iir();
        chk("R6 iir read keeps hidden source", iir, exp_iir(1, 1, 3'b011));
        p_lsr();
        chk("R6 holding empty still pending", iir, exp_iir(1, 1, 3'b001));
        p_thr();
    endtask

    task automatic t_modem();
        fifo_en = 0; ier = 4'b1000; settle();
        p_modem();
        chk("R7 modem change set", iir, 8'h00);
        p_lsr();
        chk("R7 lsr read does not clear", iir, 8'h00);
        p_msr();
        chk("R7 msr read clears", iir, 8'h01);
    endtask

    task automatic t_enables();
        fifo_en = 0; ier = 4'b0000; settle();
        p_line(); p_tx(); p_modem(); rx_level = 5'd3; settle();
        chk("R8 all disabled", iir, exp_iir(0, 0, 3'b000));
        chk("R8 irq low when disabled", {7'd0, irq}, 8'd0);
        ier = 4'b1000; settle();
        chk("R8 bit3 modem", iir, exp_iir(0, 1, 3'b000));
        ier = 4'b0010; settle();
        chk("R8 bit1 holding", iir, exp_iir(0, 1, 3'b001));
        ier = 4'b0001; settle();
        chk("R8 bit0 rx data", iir, exp_iir(0, 1, 3'b010));
        ier = 4'b0100; settle();
        chk("R8 bit2 line", iir, exp_iir(0, 1, 3'b011));
        p_lsr(); p_thr(); p_msr(); rx_level = 5'd0; settle();
        chk("R8 cleanup idle", iir, exp_iir(0, 0, 3'b000));
    endtask

    task automatic t_priority();
        fifo_en = 1; trig_sel = 2'b11; ier = 4'b1111; settle();
        p_line(); p_tx(); p_modem(); rx_level = 5'd14; settle();
        chk("R9 line first", iir, exp_iir(1, 1, 3'b011));
        p_lsr();
        chk("R9 rx data second", iir, exp_iir(1, 1, 3'b010));
        rx_level = 5'd5; settle();
        for (int k = 0; k < 4; k++) p_tick();
        chk("R9 timeout third", iir, exp_iir(1, 1, 3'b110));
        rx_level = 5'd0; settle();
        chk("R9 holding fourth", iir, exp_iir(1, 1, 3'b001));
        p_thr();
        chk("R9 modem last", iir, exp_iir(1, 1, 3'b000));
        chk("R10 FIFO mode bits", {iir[7:4], 4'h0}, 8'hC0);
        p_msr();
        chk("R1 idle FIFO mode", iir, 8'hC1);
    endtask

    task automatic t_irq_gate();
        fifo_en = 0; ier = 4'b0100; out2 = 1; settle();
        p_line();
        chk("R11 irq with out2", {7'd0, irq}, 8'd1);
        out2 = 0; settle();
        chk("R11 irq gated by out2", {7'd0, irq}, 8'd0);
        out2 = 1; p_lsr();
        chk("R11 irq drops when cleared", {7'd0, irq}, 8'd0);
    endtask

    initial begin
        t_reset();
        t_line();
        t_rxdata();
        t_timeout();
        t_txempty();
        t_modem();
        t_enables();
        t_priority();
        t_irq_gate();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule